// File: doc/BRIEF.md
# Region-Based Memory Protection Unit

This block sits beside a bus fabric and decides, for every access presented on one of several check ports, whether that access may proceed. It holds a table of programmable region descriptors. Each descriptor names an inclusive address window at 32-byte granularity, a set of access rights for every bus master, a valid bit and an optional process-identifier qualifier. An access is granted in the same cycle it is presented when at least one valid descriptor covers its address and allows that master the requested kind of access in the requested privilege mode. Descriptors may overlap, and their permissions combine by OR. An access that no descriptor allows is flagged as a fault.

Processor masters carry separate read, write and execute rights for supervisor and for user mode. Other bus masters carry only read and write rights. They can never execute, and their privilege input is ignored. The first faulting access is captured in a set of error outputs and stays there until software clears it by writing a one. Descriptors and the error clear share a single synchronous write port.

Top module: `region_guard`

## Requirements
- R1: Descriptors are written through the write port at word address {sel=0, region index, word}. Word 0 holds the start address in bits [AW-1:5]. Word 1 holds the end address in bits [AW-1:5]. Word 2 holds the rights. Word 3 is control: bit 0 valid, bit 1 PID-qualify, bits [15:8] PID. A write takes effect for checks from the next cycle onward.
- R2: A descriptor covers an address when start <= addr[AW-1:5] <= end, both bounds inclusive. Address bits [4:0] are ignored.
- R3: A requested access is granted combinationally in the same cycle when any covering, valid, permitting descriptor exists. Overlapping descriptors combine by OR.
- R4: An access covered by no valid descriptor is denied. A descriptor whose valid bit is 0 never matches.
- R5: When PID-qualify is set, a descriptor matches only when the access PID equals its PID.
- R6: Processor masters are IDs 0..N_CPU-1. Master m uses rights bits starting at m*6: +0 supervisor read, +1 supervisor write, +2 supervisor execute, +3 user read, +4 user write, +5 user execute. Privilege input 1 means supervisor.
- R7: The other masters use 2 bits each, starting at N_CPU*6 + (m-N_CPU)*2: +0 read, +1 write. Their privilege input is ignored and execute is always denied. Access type is encoded 0 read, 1 write, 2 execute, and type 3 is always denied.
- R8: All check ports are evaluated concurrently and independently. grant_o and fault_o stay low for a port whose request valid is low, and such a port captures no error.
- R9: After reset, descriptor 0 is valid, covers the whole address space, grants every right to every master and has no PID qualification. All other descriptors are invalid, and no error is flagged.
- R10: The first fault sets err_valid_o and captures the address, master, type and privilege of that access. The capture is held while the flag stays set. When several ports fault in the same cycle, the lowest port index is captured.
- R11: Writing data bit 0 = 1 to word address {sel=1, all zero} clears the error flag, and writing 0 there has no effect. A clear and a new fault in the same cycle leave the flag set with the new fault captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | WAW | Register word address |
| wr_data_i | input | DW | Register write data |
| req_valid_i | input | N_PORTS | Per-port access request |
| req_addr_i | input | N_PORTS*AW | Per-port access address |
| req_master_i | input | N_PORTS*MW | Per-port master ID |
| req_type_i | input | N_PORTS*2 | Per-port access type |
| req_priv_i | input | N_PORTS | Per-port supervisor mode |
| req_pid_i | input | N_PORTS*PIDW | Per-port process ID |
| grant_o | output | N_PORTS | Access allowed |
| fault_o | output | N_PORTS | Access requested and denied |
| err_valid_o | output | 1 | Sticky error flag |
| err_addr_o | output | AW | Captured fault address |
| err_master_o | output | MW | Captured fault master |
| err_type_o | output | 2 | Captured fault type |
| err_priv_o | output | 1 | Captured fault privilege |

## Verification
The bench builds the block with its defaults: 16 descriptors, 3 check ports and 4 masters, of which 2 are processors. With 16 descriptors, the highest table slot can be programmed and shown to match at the very top of the address space. With 3 ports, faults can be presented on two ports in one cycle while a third port is granted, which exercises the capture priority. Having two masters of each class reaches both rights layouts, the supervisor/user split and the rule that bus masters never execute.

// File: rtl/mpu_pkg.sv
package mpu_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  localparam int unsigned GRAN_BITS      = 5;
  localparam int unsigned CPU_RIGHT_BITS = 6;
  localparam int unsigned BUS_RIGHT_BITS = 2;

  function automatic int unsigned rights_width(int unsigned n_cpu, int unsigned n_masters);
    return n_cpu * CPU_RIGHT_BITS + (n_masters - n_cpu) * BUS_RIGHT_BITS;
  endfunction
endpackage

// File: rtl/mpu_desc_regs.sv
module mpu_desc_regs
  import mpu_pkg::*;
#(
  parameter int N_REGIONS = 16,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int PIDW      = 8,
  parameter int RW        = 16,
  parameter int IW        = 4,
  parameter int WAW       = IW + 3,
  localparam int TW       = AW - GRAN_BITS
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [WAW-1:0]                wr_addr_i,
  input  logic [DW-1:0]                 wr_data_i,
  output logic [N_REGIONS-1:0][TW-1:0]  start_o,
  output logic [N_REGIONS-1:0][TW-1:0]  end_o,
  output logic [N_REGIONS-1:0][RW-1:0]  rights_o,
  output logic [N_REGIONS-1:0]          valid_o,
  output logic [N_REGIONS-1:0]          pid_en_o,
  output logic [N_REGIONS-1:0][PIDW-1:0] pid_o
);

  logic          desc_sel;
  logic [IW-1:0] idx;
  logic [1:0]    word;

  assign desc_sel = wr_en_i & ~wr_addr_i[WAW-1];
  assign idx      = wr_addr_i[WAW-2:2];
  assign word     = wr_addr_i[1:0];

  for (genvar r = 0; r < N_REGIONS; r++) begin : g_desc
    localparam bit IS_BOOT = (r == 0);
    logic hit_w;
    assign hit_w = desc_sel && (idx == IW'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_o[r]  <= '0;
        end_o[r]    <= {TW{IS_BOOT}};
        rights_o[r] <= {RW{IS_BOOT}};
        valid_o[r]  <= IS_BOOT;
        pid_en_o[r] <= 1'b0;
        pid_o[r]    <= '0;
      end else if (hit_w) begin
        unique case (word)
          2'd0: start_o[r]  <= wr_data_i[AW-1:GRAN_BITS];
          2'd1: end_o[r]    <= wr_data_i[AW-1:GRAN_BITS];
          2'd2: rights_o[r] <= wr_data_i[RW-1:0];
          default: begin
            valid_o[r]  <= wr_data_i[0];
            pid_en_o[r] <= wr_data_i[1];
            pid_o[r]    <= wr_data_i[8+PIDW-1:8];
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/mpu_port_check.sv
module mpu_port_check
  import mpu_pkg::*;
#(
  parameter int N_REGIONS = 16,
  parameter int N_MASTERS = 4,
  parameter int N_CPU     = 2,
  parameter int AW        = 32,
  parameter int PIDW      = 8,
  parameter int RW        = 16,
  parameter int MW        = 2,
  localparam int TW       = AW - GRAN_BITS,
  localparam int MSEL     = 2 ** MW
) (
  input  logic [N_REGIONS-1:0][TW-1:0]   start_i,
  input  logic [N_REGIONS-1:0][TW-1:0]   end_i,
  input  logic [N_REGIONS-1:0][RW-1:0]   rights_i,
  input  logic [N_REGIONS-1:0]           valid_i,
  input  logic [N_REGIONS-1:0]           pid_en_i,
  input  logic [N_REGIONS-1:0][PIDW-1:0] pid_i,
  input  logic                           req_valid_i,
  input  logic [AW-1:0]                  req_addr_i,
  input  logic [MW-1:0]                  req_master_i,
  input  logic [1:0]                     req_type_i,
  input  logic                           req_priv_i,
  input  logic [PIDW-1:0]                req_pid_i,
  output logic                           grant_o
);

  logic [TW-1:0] blk;
  logic          is_rd, is_wr, is_ex;
  logic [N_REGIONS-1:0] hit;

  assign blk   = req_addr_i[AW-1:GRAN_BITS];
  assign is_rd = (req_type_i == ACC_READ);
  assign is_wr = (req_type_i == ACC_WRITE);
  assign is_ex = (req_type_i == ACC_EXEC);

  for (genvar r = 0; r < N_REGIONS; r++) begin : g_reg
    logic [MSEL-1:0] allow_m;
    logic in_rng, pid_ok;

    for (genvar m = 0; m < MSEL; m++) begin : g_mst
      if (m < N_CPU) begin : g_cpu
        localparam int B = m * CPU_RIGHT_BITS;
        logic rd, wr, ex;
        assign rd = req_priv_i ? rights_i[r][B]   : rights_i[r][B+3];
        assign wr = req_priv_i ? rights_i[r][B+1] : rights_i[r][B+4];
        assign ex = req_priv_i ? rights_i[r][B+2] : rights_i[r][B+5];
        assign allow_m[m] = (is_rd & rd) | (is_wr & wr) | (is_ex & ex);
      end else if (m < N_MASTERS) begin : g_bus
        localparam int B = N_CPU * CPU_RIGHT_BITS + (m - N_CPU) * BUS_RIGHT_BITS;
        assign allow_m[m] = (is_rd & rights_i[r][B]) | (is_wr & rights_i[r][B+1]);
      end else begin : g_none
        assign allow_m[m] = 1'b0;
      end
    end

    assign in_rng = (blk >= start_i[r]) && (blk <= end_i[r]);
    assign pid_ok = ~pid_en_i[r] | (pid_i[r] == req_pid_i);
    assign hit[r] = valid_i[r] & in_rng & pid_ok & allow_m[req_master_i];
  end

  assign grant_o = req_valid_i & (|hit);

endmodule

// File: rtl/mpu_err_capture.sv
module mpu_err_capture #(
  parameter int NP = 3,
  parameter int AW = 32,
  parameter int MW = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic [NP-1:0]         fault_i,
  input  logic [NP-1:0][AW-1:0] addr_i,
  input  logic [NP-1:0][MW-1:0] master_i,
  input  logic [NP-1:0][1:0]    type_i,
  input  logic [NP-1:0]         priv_i,
  output logic                  err_valid_o,
  output logic [AW-1:0]         err_addr_o,
  output logic [MW-1:0]         err_master_o,
  output logic [1:0]            err_type_o,
  output logic                  err_priv_o
);

  logic [NP:0]         taken;
  logic [NP:0][AW-1:0] addr_ch;
  logic [NP:0][MW-1:0] mst_ch;
  logic [NP:0][1:0]    typ_ch;
  logic [NP:0]         prv_ch;

  assign taken[0]   = 1'b0;
  assign addr_ch[0] = '0;
  assign mst_ch[0]  = '0;
  assign typ_ch[0]  = '0;
  assign prv_ch[0]  = 1'b0;

  // lowest index wins
  for (genvar p = 0; p < NP; p++) begin : g_pick
    logic pick;
    assign pick         = fault_i[p] & ~taken[p];
    assign taken[p+1]   = taken[p] | fault_i[p];
    assign addr_ch[p+1] = addr_ch[p] | ({AW{pick}} & addr_i[p]);
    assign mst_ch[p+1]  = mst_ch[p]  | ({MW{pick}} & master_i[p]);
    assign typ_ch[p+1]  = typ_ch[p]  | ({2{pick}}  & type_i[p]);
    assign prv_ch[p+1]  = prv_ch[p]  | (pick & priv_i[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_valid_o  <= 1'b0;
      err_addr_o   <= '0;
      err_master_o <= '0;
      err_type_o   <= '0;
      err_priv_o   <= 1'b0;
    end else if (taken[NP] && (!err_valid_o || clr_i)) begin
      err_valid_o  <= 1'b1;
      err_addr_o   <= addr_ch[NP];
      err_master_o <= mst_ch[NP];
      err_type_o   <= typ_ch[NP];
      err_priv_o   <= prv_ch[NP];
    end else if (clr_i) begin
      err_valid_o  <= 1'b0;
    end
  end

endmodule

// File: rtl/region_guard.sv
module region_guard
  import mpu_pkg::*;
#(
  parameter int N_REGIONS = 16,
  parameter int N_PORTS   = 3,
  parameter int N_MASTERS = 4,
  parameter int N_CPU     = 2,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int PIDW      = 8,
  localparam int MW       = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  localparam int IW       = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
  localparam int WAW      = IW + 3,
  localparam int RW       = rights_width(N_CPU, N_MASTERS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [WAW-1:0]            wr_addr_i,
  input  logic [DW-1:0]             wr_data_i,
  input  logic [N_PORTS-1:0]        req_valid_i,
  input  logic [N_PORTS*AW-1:0]     req_addr_i,
  input  logic [N_PORTS*MW-1:0]     req_master_i,
  input  logic [N_PORTS*2-1:0]      req_type_i,
  input  logic [N_PORTS-1:0]        req_priv_i,
  input  logic [N_PORTS*PIDW-1:0]   req_pid_i,
  output logic [N_PORTS-1:0]        grant_o,
  output logic [N_PORTS-1:0]        fault_o,
  output logic                      err_valid_o,
  output logic [AW-1:0]             err_addr_o,
  output logic [MW-1:0]             err_master_o,
  output logic [1:0]                err_type_o,
  output logic                      err_priv_o
);

  localparam int TW = AW - GRAN_BITS;

  logic [N_REGIONS-1:0][TW-1:0]   d_start, d_end;
  logic [N_REGIONS-1:0][RW-1:0]   d_rights;
  logic [N_REGIONS-1:0]           d_valid, d_pid_en;
  logic [N_REGIONS-1:0][PIDW-1:0] d_pid;

  logic [N_PORTS-1:0][AW-1:0] p_addr;
  logic [N_PORTS-1:0][MW-1:0] p_master;
  logic [N_PORTS-1:0][1:0]    p_type;
  logic                       err_clr;

  assign err_clr = wr_en_i && (wr_addr_i == {1'b1, {(WAW-1){1'b0}}}) && wr_data_i[0];

  mpu_desc_regs #(
    .N_REGIONS(N_REGIONS), .AW(AW), .DW(DW), .PIDW(PIDW), .RW(RW), .IW(IW), .WAW(WAW)
  ) i_desc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .start_o  (d_start),
    .end_o    (d_end),
    .rights_o (d_rights),
    .valid_o  (d_valid),
    .pid_en_o (d_pid_en),
    .pid_o    (d_pid)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign p_addr[p]   = req_addr_i[p*AW +: AW];
    assign p_master[p] = req_master_i[p*MW +: MW];
    assign p_type[p]   = req_type_i[p*2 +: 2];

    mpu_port_check #(
      .N_REGIONS(N_REGIONS), .N_MASTERS(N_MASTERS), .N_CPU(N_CPU),
      .AW(AW), .PIDW(PIDW), .RW(RW), .MW(MW)
    ) i_chk (
      .start_i     (d_start),
      .end_i       (d_end),
      .rights_i    (d_rights),
      .valid_i     (d_valid),
      .pid_en_i    (d_pid_en),
      .pid_i       (d_pid),
      .req_valid_i (req_valid_i[p]),
      .req_addr_i  (p_addr[p]),
      .req_master_i(p_master[p]),
      .req_type_i  (p_type[p]),
      .req_priv_i  (req_priv_i[p]),
      .req_pid_i   (req_pid_i[p*PIDW +: PIDW]),
      .grant_o     (grant_o[p])
    );

    assign fault_o[p] = req_valid_i[p] & ~grant_o[p];
  end

  mpu_err_capture #(.NP(N_PORTS), .AW(AW), .MW(MW)) i_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (err_clr),
    .fault_i     (fault_o),
    .addr_i      (p_addr),
    .master_i    (p_master),
    .type_i      (p_type),
    .priv_i      (req_priv_i),
    .err_valid_o (err_valid_o),
    .err_addr_o  (err_addr_o),
    .err_master_o(err_master_o),
    .err_type_o  (err_type_o),
    .err_priv_o  (err_priv_o)
  );

endmodule

// File: rtl/mpu_checker.sv
module mpu_checker #(
  parameter int N_REGIONS = 16,
  parameter int N_PORTS   = 3,
  parameter int N_MASTERS = 4,
  parameter int N_CPU     = 2,
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int PIDW      = 8,
  localparam int MW       = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1,
  localparam int IW       = (N_REGIONS > 1) ? $clog2(N_REGIONS) : 1,
  localparam int WAW      = IW + 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [WAW-1:0]          wr_addr_i,
  input logic [DW-1:0]           wr_data_i,
  input logic [N_PORTS-1:0]      req_valid_i,
  input logic [N_PORTS*AW-1:0]   req_addr_i,
  input logic [N_PORTS*MW-1:0]   req_master_i,
  input logic [N_PORTS*2-1:0]    req_type_i,
  input logic [N_PORTS-1:0]      req_priv_i,
  input logic [N_PORTS*PIDW-1:0] req_pid_i,
  input logic [N_PORTS-1:0]      grant_o,
  input logic [N_PORTS-1:0]      fault_o,
  input logic                    err_valid_o,
  input logic [AW-1:0]           err_addr_o,
  input logic [MW-1:0]           err_master_o,
  input logic [1:0]              err_type_o,
  input logic                    err_priv_o
);

  localparam logic [MW-1:0] CPU_LIM = MW'(N_CPU);

  logic clr_wr;
  assign clr_wr = wr_en_i && (wr_addr_i == {1'b1, {(WAW-1){1'b0}}}) && wr_data_i[0];

  for (genvar p = 0; p < N_PORTS; p++) begin : g_p
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_o[p] |-> req_valid_i[p]); // R8
    AST_BUS_NO_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_master_i[p*MW +: MW] >= CPU_LIM) && (req_type_i[p*2 +: 2] == 2'd2) |-> !grant_o[p]); // R7
    AST_RSVD_TYPE_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_type_i[p*2 +: 2] == 2'd3) |-> !grant_o[p]); // R7
  end

  AST_ERR_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_valid_o && (|fault_o) |=> err_valid_o); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o && !clr_wr |=> err_valid_o); // R10
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o && !clr_wr |=> $stable(err_addr_o) && $stable(err_master_o)
                               && $stable(err_type_o) && $stable(err_priv_o)); // R10
  AST_ERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !(|fault_o) |=> !err_valid_o); // R11
  AST_CLR_WITH_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && (|fault_o) |=> err_valid_o); // R11

endmodule

bind region_guard mpu_checker #(
  .N_REGIONS(N_REGIONS), .N_PORTS(N_PORTS), .N_MASTERS(N_MASTERS), .N_CPU(N_CPU),
  .AW(AW), .DW(DW), .PIDW(PIDW)
) i_mpu_checker (.*);

// File: tb/test_region_guard.sv
module test_region_guard;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;

  logic        v_v [NP];
  logic [31:0] a_v [NP];
  logic [1:0]  m_v [NP];
  logic [1:0]  t_v [NP];
  logic        pr_v [NP];
  logic [7:0]  pid_v [NP];

  logic [NP-1:0]    grant, fault;
  logic             err_valid;
  logic [31:0]      err_addr;
  logic [1:0]       err_master, err_type;
  logic             err_priv;

  region_guard i_region_guard (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .req_valid_i({v_v[2], v_v[1], v_v[0]}),
    .req_addr_i({a_v[2], a_v[1], a_v[0]}),
    .req_master_i({m_v[2], m_v[1], m_v[0]}),
    .req_type_i({t_v[2], t_v[1], t_v[0]}),
    .req_priv_i({pr_v[2], pr_v[1], pr_v[0]}),
    .req_pid_i({pid_v[2], pid_v[1], pid_v[0]}),
    .grant_o(grant), .fault_o(fault),
    .err_valid_o(err_valid), .err_addr_o(err_addr),
    .err_master_o(err_master), .err_type_o(err_type), .err_priv_o(err_priv)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [1:0]  m;
    logic [1:0]  t;
    logic        pr;
    logic [7:0]  pid;
    logic [31:0] a;
    logic        g;
    logic [3:0]  rq;
  } vec_t;

  // types: 0 read, 1 write, 2 exec, 3 reserved
  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_1000, 1'b1, 4'd2},  // R2 start bound
    '{2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_0FFF, 1'b0, 4'd4},  // R4 no region
    '{2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_1FFF, 1'b1, 4'd2},  // R2 end inclusive
    '{2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_2000, 1'b0, 4'd4},  // R4
    '{2'd0, 2'd1, 1'b0, 8'h00, 32'h0000_1100, 1'b0, 4'd6},  // R6 user write
    '{2'd0, 2'd0, 1'b0, 8'h00, 32'h0000_1100, 1'b1, 4'd6},  // R6 user read
    '{2'd0, 2'd2, 1'b0, 8'h00, 32'h0000_1100, 1'b0, 4'd6},  // R6 user exec
    '{2'd0, 2'd2, 1'b1, 8'h00, 32'h0000_1100, 1'b1, 4'd6},  // R6 sup exec
    '{2'd2, 2'd0, 1'b0, 8'h00, 32'h0000_1900, 1'b1, 4'd3},  // R3 overlap read
    '{2'd2, 2'd1, 1'b0, 8'h5A, 32'h0000_1900, 1'b1, 4'd5},  // R5 pid hit
    '{2'd2, 2'd1, 1'b0, 8'h11, 32'h0000_1900, 1'b0, 4'd5},  // R5 pid miss
    '{2'd2, 2'd2, 1'b1, 8'h5A, 32'h0000_1900, 1'b0, 4'd7},  // R7 bus exec
    '{2'd2, 2'd1, 1'b0, 8'h5A, 32'h0000_1100, 1'b0, 4'd3},  // R3
    '{2'd1, 2'd2, 1'b0, 8'h5A, 32'h0000_2000, 1'b1, 4'd5},  // R5
    '{2'd1, 2'd2, 1'b0, 8'h00, 32'h0000_2000, 1'b0, 4'd5},  // R5
    '{2'd1, 2'd2, 1'b1, 8'h5A, 32'h0000_2000, 1'b0, 4'd6},  // R6 sup lacks
    '{2'd3, 2'd0, 1'b1, 8'h00, 32'hFFFF_FFFF, 1'b1, 4'd1},  // R1 region 15
    '{2'd3, 2'd1, 1'b0, 8'h00, 32'hF000_0000, 1'b1, 4'd7},  // R7 priv ignored
    '{2'd3, 2'd0, 1'b1, 8'h00, 32'hEFFF_FFE0, 1'b0, 4'd2},  // R2
    '{2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_3000, 1'b0, 4'd4},  // R4 invalid desc
    '{2'd1, 2'd3, 1'b0, 8'h5A, 32'h0000_2000, 1'b0, 4'd7},  // R7 reserved type
    '{2'd2, 2'd1, 1'b0, 8'h5A, 32'h0000_27FF, 1'b1, 4'd2},  // R2
    '{2'd2, 2'd1, 1'b0, 8'h5A, 32'h0000_2800, 1'b0, 4'd2},  // R2
    '{2'd2, 2'd1, 1'b0, 8'h5A, 32'h0000_17FF, 1'b0, 4'd2},  // R2
    '{2'd2, 2'd1, 1'b0, 8'h5A, 32'h0000_1800, 1'b1, 4'd2}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic drive(input logic [1:0] p, input logic [1:0] m, input logic [1:0] t,
                       input logic pr, input logic [7:0] pid, input logic [31:0] a);
    v_v[p] = 1'b1; m_v[p] = m; t_v[p] = t; pr_v[p] = pr; pid_v[p] = pid; a_v[p] = a;
  endtask

  task automatic idle();
    for (int p = 0; p < NP; p++) v_v[p] = 1'b0;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin
      v_v[p] = 1'b0; a_v[p] = '0; m_v[p] = '0; t_v[p] = '0; pr_v[p] = 1'b0; pid_v[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    @(negedge clk);
    check("R9 err_valid after reset", {31'b0, err_valid}, 32'd0);
    drive(2'd0, 2'd2, 2'd0, 1'b0, 8'h00, 32'h1234_5678); #1;
    check("R9 bus read via region 0", {31'b0, grant[0]}, 32'd1);
    drive(2'd1, 2'd1, 2'd2, 1'b0, 8'h33, 32'h0000_0000); #1;
    check("R9 cpu user exec via region 0", {31'b0, grant[1]}, 32'd1);
    drive(2'd2, 2'd3, 2'd2, 1'b1, 8'h00, 32'h0000_4000); #1;
    check("R7 bus exec denied at reset", {31'b0, grant[2]}, 32'd0);
    @(negedge clk); idle();

    // R1 programming
    wr(7'd3, 32'h0);                              // region 0 off
    wr(7'd4, 32'h0000_1000); wr(7'd5, 32'h0000_1FFF);
    wr(7'd6, 32'h0000_100F); wr(7'd7, 32'h1);
    wr(7'd8, 32'h0000_1800); wr(7'd9, 32'h0000_27FF);
    wr(7'd10, 32'h0000_2E00); wr(7'd11, 32'h5A03);
    wr(7'd12, 32'h0000_3000); wr(7'd13, 32'h0000_3FFF);
    wr(7'd14, 32'h0000_FFFF); wr(7'd15, 32'h0);
    wr(7'd60, 32'hF000_0000); wr(7'd61, 32'hFFFF_FFFF);
    wr(7'd62, 32'h0000_C000); wr(7'd63, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] p;
      p = 2'(i % NP);
      @(negedge clk);
      idle();
      drive(p, VECS[i].m, VECS[i].t, VECS[i].pr, VECS[i].pid, VECS[i].a);
      #1;
      check($sformatf("R%0d vec %0d grant", VECS[i].rq, i), {31'b0, grant[p]}, {31'b0, VECS[i].g});
      check($sformatf("R%0d vec %0d fault", VECS[i].rq, i), {31'b0, fault[p]}, {31'b0, ~VECS[i].g});
    end
    @(negedge clk); idle();

    // R11 clear
    wr(7'h40, 32'h1); #1;
    check("R11 clear by writing one", {31'b0, err_valid}, 32'd0);

    // R10 first violation held
    drive(2'd0, 2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_0FFF);
    @(negedge clk);
    drive(2'd0, 2'd1, 2'd0, 1'b0, 8'h00, 32'h0000_3000);
    @(negedge clk); idle(); #1;
    check("R10 flag set", {31'b0, err_valid}, 32'd1);
    check("R10 first addr held", err_addr, 32'h0000_0FFF);
    check("R10 first master", {30'b0, err_master}, 32'd0);
    check("R10 first priv", {31'b0, err_priv}, 32'd1);

    // R8 concurrent ports, R10 lowest index captured
    wr(7'h40, 32'h1);
    drive(2'd0, 2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_1000);
    drive(2'd1, 2'd3, 2'd1, 1'b0, 8'h00, 32'h0000_5000);
    drive(2'd2, 2'd2, 2'd2, 1'b0, 8'h5A, 32'h0000_1900);
    #1;
    check("R8 concurrent grants", {29'b0, grant}, 32'b001);
    check("R8 concurrent faults", {29'b0, fault}, 32'b110);
    @(negedge clk); idle(); #1;
    check("R10 port priority addr", err_addr, 32'h0000_5000);
    check("R10 port priority master", {30'b0, err_master}, 32'd3);
    check("R10 port priority type", {30'b0, err_type}, 32'd1);
    check("R10 port priority priv", {31'b0, err_priv}, 32'd0);

    // R11 writing zero has no effect
    wr(7'h40, 32'h0); #1;
    check("R11 zero write keeps flag", {31'b0, err_valid}, 32'd1);
    check("R11 zero write keeps addr", err_addr, 32'h0000_5000);

    // R11 clear and fault in same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'h40; wr_data = 32'h1;
    drive(2'd2, 2'd1, 2'd0, 1'b0, 8'h00, 32'h0000_4440);
    @(negedge clk); wr_en = 1'b0; idle(); #1;
    check("R11 same-cycle flag", {31'b0, err_valid}, 32'd1);
    check("R11 same-cycle addr", err_addr, 32'h0000_4440);
    check("R11 same-cycle master", {30'b0, err_master}, 32'd1);

    // R8 idle port neither grants nor captures
    wr(7'h40, 32'h1);
    drive(2'd0, 2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_0FFF);
    v_v[0] = 1'b0; #1;
    check("R8 idle port grant", {31'b0, grant[0]}, 32'd0);
    check("R8 idle port fault", {31'b0, fault[0]}, 32'd0);
    @(negedge clk); #1;
    check("R8 idle port no capture", {31'b0, err_valid}, 32'd0);

    // R1 write visible next cycle; R4 region 3 now valid
    wr(7'd15, 32'h1);
    drive(2'd1, 2'd0, 2'd0, 1'b1, 8'h00, 32'h0000_3000); #1;
    check("R1 valid write takes effect", {31'b0, grant[1]}, 32'd1);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R) actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule